// File: doc/BRIEF.md
# Step-of-Three Up/Down Counter

This block is a synchronous 4-bit counter that visits only the multiples of three between 0 and 15. It counts upward or downward, as a direction input selects, and it advances only on clock edges where the enable input is high. An active-low asynchronous reset returns it to 0. It fits wherever a cyclic index over six evenly spaced points is needed, for example phase-slot or sample-interleave selection.

The state is held in JK flip-flops. Each flip-flop's J and K terms are derived from the excitation rule: set a bit that must rise, clear a bit that must fall, and leave both low otherwise. The `ENCODED` parameter selects between two structures. With `ENCODED = 0`, four JK flops hold the output value directly. With `ENCODED = 1`, three JK flops hold a modulo-6 index, and a combinational decoder maps index i to the value 3*i. If the state register ever holds a value outside the legal set, the next enabled edge returns it to 0.

Top module: `step3_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0. The reset takes effect at once and does not wait for a clock edge.
- R2: On each rising edge with en_i=1 and up_i=1, count_o steps through 0, 3, 6, 9, 12, 15 in that order, and 15 is followed by 0.
- R3: On each rising edge with en_i=1 and up_i=0, count_o steps through 15, 12, 9, 6, 3, 0 in that order, and 0 is followed by 15.
- R4: On a rising edge with en_i=0, count_o keeps its value whatever up_i is.
- R5: A change of up_i applies from the next enabled edge. From 6, for example, the counter moves to 9 when up_i=1 and to 3 when up_i=0.
- R6: Once reset has been released, count_o is always a multiple of three in the range 0 to 15.
- R7: The encoded variant (ENCODED=1) produces, cycle by cycle, the same count_o as the direct variant (ENCODED=0) for the same input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; forces the count to 0 |
| en_i | input | 1 | Count enable; while low the count holds |
| up_i | input | 1 | Direction select: 1 counts up, 0 counts down |
| count_o | output | 4 | Present count value (0, 3, 6, 9, 12 or 15) |

## Verification
The bench runs several input patterns. Long unbroken runs in one direction cover every forward transition, including the 15-to-0 wrap, and every reverse transition, including the 0-to-15 wrap. Patterns that flip direction on every edge, or at each value in turn, show whether the direction is sampled on the edge itself or one cycle late. Patterns with enable gaps, where up_i toggles during the pause, show whether a disabled edge can move the count. An asynchronous reset pulse in the middle of a cycle shows whether the clear waits for a clock edge. Both variants run side by side against one behavioural model, so a fault in the mapping from index to value shows up as a mismatch on R7.

// File: rtl/step3_pkg.sv
package step3_pkg;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned STEP    = 3;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  localparam int unsigned N_STATE = CNT_MAX / STEP + 1;
  localparam int unsigned IDX_W   = $clog2(N_STATE);

  // next value, direct encoding; non-multiples recover to 0
  function automatic logic [CNT_W-1:0] direct_next(input logic [CNT_W-1:0] q, input logic up);
    logic [CNT_W-1:0] r;
    r = '0;
    if ((int'(q) % STEP) == 0) begin
      if (up) r = (int'(q) == CNT_MAX) ? '0 : CNT_W'(int'(q) + STEP);
      else    r = (q == '0) ? CNT_W'(CNT_MAX) : CNT_W'(int'(q) - STEP);
    end
    return r;
  endfunction

  // next index, modulo-N_STATE encoding; out-of-range recovers to 0
  function automatic logic [IDX_W-1:0] index_next(input logic [IDX_W-1:0] s, input logic up);
    logic [IDX_W-1:0] r;
    r = '0;
    if (int'(s) < N_STATE) begin
      if (up) r = (int'(s) == N_STATE - 1) ? '0 : IDX_W'(int'(s) + 1);
      else    r = (s == '0) ? IDX_W'(N_STATE - 1) : IDX_W'(int'(s) - 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/jk_ff.sv
module jk_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else if (en_i) begin
      unique case ({j_i, k_i})
        2'b00: q_o <= q_o;
        2'b01: q_o <= 1'b0;
        2'b10: q_o <= 1'b1;
        2'b11: q_o <= ~q_o;
      endcase
    end
  end
endmodule

// File: rtl/jk_reg.sv
module jk_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] j, k;

  // excitation: set rising bits, clear falling bits, otherwise hold
  assign j = ~q_o & nxt_i;
  assign k = q_o & ~nxt_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    jk_ff u_ff (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .j_i   (j[b]),
      .k_i   (k[b]),
      .q_o   (q_o[b])
    );
  end
endmodule

// File: rtl/step3_decode.sv
module step3_decode
  import step3_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_STATE; i++)
      if (int'(idx_i) == i) cnt_o = CNT_W'(i * STEP);
  end
endmodule

// File: rtl/step3_counter.sv
module step3_counter
  import step3_pkg::*;
#(
  parameter bit ENCODED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] count_o
);
  if (!ENCODED) begin : g_direct
    logic [CNT_W-1:0] q, nxt;
    assign nxt = direct_next(q, up_i);
    jk_reg #(.W(CNT_W)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .nxt_i(nxt), .q_o(q)
    );
    assign count_o = q;
  end else begin : g_encoded
    logic [IDX_W-1:0] s, nxt;
    assign nxt = index_next(s, up_i);
    jk_reg #(.W(IDX_W)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .nxt_i(nxt), .q_o(s)
    );
    step3_decode u_dec (.idx_i(s), .cnt_o(count_o));
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_o));
  p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && int'(count_o) != CNT_MAX) |=> int'(count_o) == int'($past(count_o)) + STEP);
  p_up_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && int'(count_o) == CNT_MAX) |=> count_o == '0);
  p_down_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !up_i && count_o != '0) |=> int'(count_o) == int'($past(count_o)) - STEP);
  p_down_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !up_i && count_o == '0) |=> int'(count_o) == CNT_MAX);
  p_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_o) % STEP) == 0);
endmodule

// File: tb/step3_counter_tb.sv
module step3_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic up = 1'b1;
  logic [3:0] cnt_d, cnt_e;
  int n_run = 0, n_fail = 0;
  int idx = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  step3_counter #(.ENCODED(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .up_i(up), .count_o(cnt_d));
  step3_counter #(.ENCODED(1'b1)) u_dut_enc (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .up_i(up), .count_o(cnt_e));

  task automatic check(input string tag);
    int exp_v = idx * 3;
    n_run++;
    if (int'(cnt_d) != exp_v) begin
      n_fail++;
      $display("FAIL %s direct: got %0d expected %0d", tag, cnt_d, exp_v);
    end
    n_run++;
    if (int'(cnt_e) != exp_v) begin
      n_fail++;
      $display("FAIL R7 (%s) encoded: got %0d expected %0d", tag, cnt_e, exp_v);
    end
    n_run++;
    if ((int'(cnt_d) % 3) != 0 || (int'(cnt_e) % 3) != 0) begin
      n_fail++;
      $display("FAIL R6: got %0d/%0d expected a multiple of 3", cnt_d, cnt_e);
    end
  endtask

  // drive at negedge, model at posedge, sample at following negedge
  task automatic cyc(input logic e, input logic u, input string tag);
    en = e; up = u;
    @(posedge clk);
    if (e) idx = u ? (idx + 1) % 6 : (idx + 5) % 6;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, "R2");
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, "R3");
    for (int i = 0; i < 4; i++) cyc(1'b0, i[0], "R4");
    cyc(1'b1, 1'b1, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b0, ~i[0], "R4");
    // alternate direction every edge
    for (int i = 0; i < 6; i++) cyc(1'b1, i[0], "R5");
    // reach 6, then test both directions
    while (idx != 2) cyc(1'b1, 1'b1, "R2");
    cyc(1'b1, 1'b0, "R5");
    cyc(1'b1, 1'b1, "R5");
    cyc(1'b1, 1'b1, "R5");
    // enable gaps interleaved with motion
    for (int i = 0; i < 12; i++) cyc(i % 3 != 0, i[1], "R4");
    // asynchronous reset in mid-cycle
    while (idx != 4) cyc(1'b1, 1'b1, "R2");
    #1 rst_n = 1'b0;
    #0.5 idx = 0;
    check("R1");
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, "R3");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule